// File: doc/BRIEF.md
# Palette and Mode Command Register Block

This block is the write-only command port of a retro video and memory controller. The CPU writes one 8-bit command byte at a time, and the two top bits of the byte pick what it does. A byte can point at a pen or at the border. It can store a 5-bit hardware colour code into the entry being pointed at. It can also set the screen mode, the lower-ROM overlay and an interrupt-control request. The block holds seventeen colour entries: sixteen pens and one border.

The pixel pipeline reads the colours through two combinational lookup ports. The pen lookup masks the incoming pen index to the number of pens that the active screen mode allows. A mode write is only staged at first. It becomes active at the next rising edge of horizontal sync, so a mode never changes in the middle of a line. The lower-ROM enable steers CPU reads in the bottom 16 KiB of the address space to ROM. Writes in that range always reach RAM.

Top module: `palette_mode_regs`

## Requirements
- R1: After a synchronous active-low reset, the pointer selects pen 0 and all seventeen entries hold 0. Both the active and the staged mode are 1. The lower ROM is enabled and the interrupt pulse is low.
- R2: A byte with bits 7:6 = 00 and bit 4 = 0 points at the pen numbered by bits 3:0. The pointer keeps its value across any number of colour writes.
- R3: A byte with bits 7:6 = 00 and bit 4 = 1 points at the border entry, whatever bits 3:0 hold.
- R4: A byte with bits 7:6 = 01 stores bits 4:0 into the entry being pointed at. Every one of the 32 codes can be stored. The lookup ports show the new value from the cycle after the write edge.
- R5: A byte with bits 7:6 = 10 loads bits 1:0 into the staged mode. The active mode takes the staged value only at a clock edge where hsync is sampled high after being sampled low. A mode write at that same edge waits for the following hsync rise.
- R6: In a mode/ROM byte, bit 2 = 0 enables the lower ROM and bit 2 = 1 disables it. `rom_read_sel` is high only for a read (`mem_rd` = 1) below address 0x4000 while the ROM is enabled.
- R7: A mode/ROM byte with bit 4 = 1 raises `irq_ctl_pulse` for exactly the one cycle after the write edge. With bit 4 = 0 the pulse stays low.
- R8: A byte with bits 7:6 = 11 changes no entry, pointer, mode or ROM state.
- R9: The pen lookup uses index bits 3:0 in active mode 0 and mode 3, bits 1:0 in mode 1, and bit 0 in mode 2.
- R10: The border lookup always returns the border entry, whatever the pen index is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| hsync | input | 1 | Horizontal sync level |
| pen_idx | input | 4 | Pen index from the pixel pipeline |
| pen_color | output | 5 | Colour code of the masked pen |
| border_color | output | 5 | Colour code of the border entry |
| mode_active | output | 2 | Screen mode in force |
| mode_pending | output | 2 | Staged screen mode |
| mem_rd | input | 1 | CPU read cycle |
| mem_addr | input | 16 | CPU address |
| rom_lo_en | output | 1 | Lower-ROM overlay enable |
| rom_read_sel | output | 1 | Steer the current read to ROM |
| irq_ctl_pulse | output | 1 | One-cycle interrupt-control request |

## Verification
The bench writes a border select whose low four bits are non-zero. A design that decodes those bits would corrupt a pen rather than the border. It stores codes 31 and 30 to show that no high code is folded onto a smaller one. It also repeats colour writes without reselecting, which exposes a pointer that clears itself. It sends a mode write at the same edge as an hsync rise: a design that forwards the new mode straight through would switch mode in the middle of a line. Reads at 0x3FFF and 0x4000 pin down the edge of the ROM window. Indices 15 and 14 in modes 1 and 2 show whether the mask follows the active mode or the staged one.

// File: rtl/pmr_pkg.sv
// Package: command classes and sizes shared by the palette/mode block.
// Assumes 8-bit command bytes whose class sits in bits 7:6.
package pmr_pkg;
    localparam int CMD_W   = 8;
    localparam int COLOR_W = 5;
    localparam int MODE_W  = 2;

    typedef enum logic [1:0] {
        CMD_PEN_SEL = 2'b00,
        CMD_COLOR   = 2'b01,
        CMD_MODE    = 2'b10,
        CMD_NOP     = 2'b11
    } cmd_kind_t;
endpackage

// File: rtl/pmr_decode.sv
// Command decoder: splits a strobed command byte into per-function write
// enables and operand fields. Purely combinational; assumes one byte per strobe.
module pmr_decode
    import pmr_pkg::*;
(
    input  logic                cmd_we,
    input  logic [CMD_W-1:0]    cmd_byte,
    output logic                pen_sel_we,
    output logic                color_we,
    output logic                mode_we,
    output logic                sel_border,
    output logic [3:0]          sel_pen,
    output logic [COLOR_W-1:0]  color_val,
    output logic [MODE_W-1:0]   mode_val,
    output logic                rom_off,
    output logic                irq_req
);
    cmd_kind_t kind;
    logic      unused_bit5;

    // Class the byte from its top two bits and gate with the strobe.
    always_comb begin
        kind       = cmd_kind_t'(cmd_byte[7:6]);
        pen_sel_we = cmd_we && (kind == CMD_PEN_SEL);
        color_we   = cmd_we && (kind == CMD_COLOR);
        mode_we    = cmd_we && (kind == CMD_MODE);
    end

    // Operand fields; each consumer reads only the fields of its own class.
    always_comb begin
        sel_border = cmd_byte[4];
        sel_pen    = cmd_byte[3:0];
        color_val  = cmd_byte[COLOR_W-1:0];
        mode_val   = cmd_byte[MODE_W-1:0];
        rom_off    = cmd_byte[2];
        irq_req    = cmd_byte[4];
    end

    assign unused_bit5 = cmd_byte[5];
endmodule

// File: rtl/pmr_palette.sv
// Palette store: a pointer register plus NUM_PENS pen entries and one border
// entry. Lookups are combinational. The pen index is masked by the active mode.
// Assumes the border entry sits at index NUM_PENS.
module pmr_palette
    import pmr_pkg::*;
#(
    parameter int NUM_PENS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pen_sel_we,
    input  logic                         color_we,
    input  logic                         sel_border,
    input  logic [$clog2(NUM_PENS)-1:0]  sel_pen,
    input  logic [COLOR_W-1:0]           color_val,
    input  logic [MODE_W-1:0]            mode_active,
    input  logic [$clog2(NUM_PENS)-1:0]  pen_idx,
    output logic [COLOR_W-1:0]           pen_color,
    output logic [COLOR_W-1:0]           border_color
);
    localparam int IDX_W   = $clog2(NUM_PENS);
    localparam int ENTRIES = NUM_PENS + 1;
    localparam int PTR_W   = $clog2(ENTRIES);
    localparam logic [PTR_W-1:0] BORDER_PTR = PTR_W'(NUM_PENS);
    localparam logic [IDX_W-1:0] MASK_M1    = IDX_W'(3);
    localparam logic [IDX_W-1:0] MASK_M2    = IDX_W'(1);

    logic [PTR_W-1:0]   ptr;
    logic [COLOR_W-1:0] pal [ENTRIES];
    logic [IDX_W-1:0]   idx_mask;

    // Pointer: follows pen-select commands, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (pen_sel_we)
            ptr <= sel_border ? BORDER_PTR : PTR_W'(sel_pen);
    end

    // One register per entry, written when it is the pointed-at entry.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                pal[e] <= '0;
            else if (color_we && (ptr == PTR_W'(e)))
                pal[e] <= color_val;
        end
    end

    // Index mask from the number of pens the active mode allows.
    always_comb begin
        case (mode_active)
            2'd1:    idx_mask = MASK_M1;
            2'd2:    idx_mask = MASK_M2;
            default: idx_mask = '1;
        endcase
    end

    assign pen_color    = pal[PTR_W'(pen_idx & idx_mask)];
    assign border_color = pal[NUM_PENS];

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= BORDER_PTR); // R3
    AST_BORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !color_we |=> $stable(border_color)); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pen_sel_we |=> $stable(ptr)); // R2
endmodule

// File: rtl/pmr_mode.sv
// Mode and ROM control: staged mode promoted on an hsync rise, the lower-ROM
// enable with read steering, and a one-cycle interrupt-control pulse.
// Assumes hsync is synchronous to clk.
module pmr_mode
    import pmr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ROM_SIZE = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              rom_off,
    input  logic              irq_req,
    input  logic              hsync,
    input  logic              mem_rd,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [MODE_W-1:0] mode_active,
    output logic [MODE_W-1:0] mode_pending,
    output logic              rom_lo_en,
    output logic              rom_read_sel,
    output logic              irq_ctl_pulse
);
    localparam logic [MODE_W-1:0] RESET_MODE = MODE_W'(1);
    localparam logic [ADDR_W-1:0] ROM_TOP    = ADDR_W'(ROM_SIZE);

    logic hsync_q;
    logic hs_rise;

    assign hs_rise = hsync && !hsync_q;

    // Previous hsync sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hsync_q <= 1'b0;
        else        hsync_q <= hsync;
    end

    // Staged mode loads on a write; active mode loads on an hsync rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pending <= RESET_MODE;
            mode_active  <= RESET_MODE;
        end else begin
            if (mode_we) mode_pending <= mode_val;
            if (hs_rise) mode_active  <= mode_pending;
        end
    end

    // Lower-ROM enable (bit clear means enabled) and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_lo_en     <= 1'b1;
            irq_ctl_pulse <= 1'b0;
        end else begin
            if (mode_we) rom_lo_en <= !rom_off;
            irq_ctl_pulse <= mode_we && irq_req;
        end
    end

    // Read steering: only reads inside the ROM window go to ROM.
    assign rom_read_sel = mem_rd && rom_lo_en && (mem_addr < ROM_TOP);

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_rise |=> $stable(mode_active)); // R5
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (mode_active == $past(mode_pending))); // R5
    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(rom_lo_en)); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ctl_pulse |-> $past(mode_we && irq_req)); // R7
endmodule

// File: rtl/palette_mode_regs.sv
// Top: command decoder, palette store and mode/ROM control.
// Assumes commands and hsync are synchronous to clk.
module palette_mode_regs
    import pmr_pkg::*;
#(
    parameter int NUM_PENS = 16,
    parameter int ADDR_W   = 16,
    parameter int ROM_SIZE = 16384
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_we,
    input  logic [CMD_W-1:0]             cmd_byte,
    input  logic                         hsync,
    input  logic [$clog2(NUM_PENS)-1:0]  pen_idx,
    output logic [COLOR_W-1:0]           pen_color,
    output logic [COLOR_W-1:0]           border_color,
    output logic [MODE_W-1:0]            mode_active,
    output logic [MODE_W-1:0]            mode_pending,
    input  logic                         mem_rd,
    input  logic [ADDR_W-1:0]            mem_addr,
    output logic                         rom_lo_en,
    output logic                         rom_read_sel,
    output logic                         irq_ctl_pulse
);
    localparam int IDX_W = $clog2(NUM_PENS);

    logic               pen_sel_we, color_we, mode_we;
    logic               sel_border, rom_off, irq_req;
    logic [3:0]         sel_pen;
    logic [COLOR_W-1:0] color_val;
    logic [MODE_W-1:0]  mode_val;

    pmr_decode u_decode (
        .cmd_we     (cmd_we),
        .cmd_byte   (cmd_byte),
        .pen_sel_we (pen_sel_we),
        .color_we   (color_we),
        .mode_we    (mode_we),
        .sel_border (sel_border),
        .sel_pen    (sel_pen),
        .color_val  (color_val),
        .mode_val   (mode_val),
        .rom_off    (rom_off),
        .irq_req    (irq_req)
    );

    pmr_palette #(.NUM_PENS(NUM_PENS)) u_palette (
        .clk          (clk),
        .rst_n        (rst_n),
        .pen_sel_we   (pen_sel_we),
        .color_we     (color_we),
        .sel_border   (sel_border),
        .sel_pen      (sel_pen[IDX_W-1:0]),
        .color_val    (color_val),
        .mode_active  (mode_active),
        .pen_idx      (pen_idx),
        .pen_color    (pen_color),
        .border_color (border_color)
    );

    pmr_mode #(.ADDR_W(ADDR_W), .ROM_SIZE(ROM_SIZE)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_we       (mode_we),
        .mode_val      (mode_val),
        .rom_off       (rom_off),
        .irq_req       (irq_req),
        .hsync         (hsync),
        .mem_rd        (mem_rd),
        .mem_addr      (mem_addr),
        .mode_active   (mode_active),
        .mode_pending  (mode_pending),
        .rom_lo_en     (rom_lo_en),
        .rom_read_sel  (rom_read_sel),
        .irq_ctl_pulse (irq_ctl_pulse)
    );
endmodule

// File: tb/test_palette_mode_regs.sv
`timescale 1ns/1ps
module test_palette_mode_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        hsync = 1'b0;
    logic [3:0]  pen_idx = '0;
    logic [4:0]  pen_color, border_color;
    logic [1:0]  mode_active, mode_pending;
    logic        mem_rd = 1'b0;
    logic [15:0] mem_addr = '0;
    logic        rom_lo_en, rom_read_sel, irq_ctl_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    palette_mode_regs i_palette_mode_regs (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .hsync(hsync), .pen_idx(pen_idx), .pen_color(pen_color),
        .border_color(border_color), .mode_active(mode_active),
        .mode_pending(mode_pending), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .rom_lo_en(rom_lo_en), .rom_read_sel(rom_read_sel),
        .irq_ctl_pulse(irq_ctl_pulse)
    );

    // Vector: {command, probe index, expected pen colour, expected border}
    localparam logic [21:0] VEC [12] = '{
        {8'h03, 4'd3,  5'd0,  5'd0},   // R2 point at pen 3
        {8'h55, 4'd3,  5'd21, 5'd0},   // R4 store 21
        {8'h5F, 4'd3,  5'd31, 5'd0},   // R2 R4 pointer kept, code 31
        {8'h1A, 4'd10, 5'd0,  5'd0},   // R3 border, low bits ignored
        {8'h47, 4'd10, 5'd0,  5'd7},   // R3 R10 border gets 7, pen 10 untouched
        {8'h0F, 4'd15, 5'd0,  5'd7},   // R2 pen 15
        {8'h5E, 4'd15, 5'd30, 5'd7},   // R4 code 30
        {8'hDF, 4'd15, 5'd30, 5'd7},   // R8 class 11 ignored
        {8'h00, 4'd0,  5'd0,  5'd7},   // R2 pen 0
        {8'h4C, 4'd0,  5'd12, 5'd7},   // R4 store 12
        {8'h01, 4'd1,  5'd0,  5'd7},   // R2 pen 1
        {8'h49, 4'd1,  5'd9,  5'd7}    // R4 store 9
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); cmd_we = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic hs_pulse();
        @(negedge clk); hsync = 1'b1;
        @(negedge clk); hsync = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pen", pen_color, 0);
        chk("R1 border", border_color, 0);
        chk("R1 active", mode_active, 1);
        chk("R1 pending", mode_pending, 1);
        chk("R1 rom", rom_lo_en, 1);
        chk("R1 pulse", irq_ctl_pulse, 0);

        // Mode 0 for full-index lookups
        wr(8'h80);
        chk("R5 active before hsync", mode_active, 1);
        hs_pulse();
        chk("R5 active after hsync", mode_active, 0);

        for (int i = 0; i < 12; i++) begin
            pen_idx = VEC[i][13:10];
            wr(VEC[i][21:14]);
            chk("R2/R3/R4 pen", pen_color, int'(VEC[i][9:5]));
            chk("R10 border", border_color, int'(VEC[i][4:0]));
        end

        // R8: class 11 leaves mode, ROM and pointer alone
        wr(8'hFF);
        chk("R8 pending", mode_pending, 0);
        chk("R8 rom", rom_lo_en, 1);
        wr(8'h4B);
        pen_idx = 4'd1; #0.1;
        chk("R8 pointer kept pen1", pen_color, 11);
        chk("R8 border", border_color, 7);

        // R5: staged mode waits for hsync
        wr(8'h81);
        chk("R5 pending", mode_pending, 1);
        repeat (3) @(negedge clk);
        chk("R5 held", mode_active, 0);
        hs_pulse();
        chk("R5 promoted", mode_active, 1);
        // R9 mode 1
        pen_idx = 4'd15; #0.1;
        chk("R9 mode1 idx15", pen_color, 31);
        pen_idx = 4'd4; #0.1;
        chk("R9 mode1 idx4", pen_color, 12);

        // R5: write at the same edge as the hsync rise waits
        @(negedge clk); cmd_we = 1'b1; cmd_byte = 8'h82; hsync = 1'b1;
        @(negedge clk); cmd_we = 1'b0; hsync = 1'b0;
        chk("R5 coincident active", mode_active, 1);
        chk("R5 coincident pending", mode_pending, 2);
        hs_pulse();
        chk("R5 next rise", mode_active, 2);
        // R9 mode 2
        pen_idx = 4'd15; #0.1;
        chk("R9 mode2 idx15", pen_color, 11);
        pen_idx = 4'd14; #0.1;
        chk("R9 mode2 idx14", pen_color, 12);

        // R6 ROM window
        mem_rd = 1'b1; mem_addr = 16'h1234; #0.1;
        chk("R6 low read", rom_read_sel, 1);
        mem_addr = 16'h3FFF; #0.1;
        chk("R6 top of window", rom_read_sel, 1);
        mem_addr = 16'h4000; #0.1;
        chk("R6 above window", rom_read_sel, 0);
        wr(8'h84);
        mem_addr = 16'h1234; #0.1;
        chk("R6 disabled", rom_lo_en, 0);
        chk("R6 disabled read", rom_read_sel, 0);
        wr(8'h80);
        chk("R6 reenabled", rom_lo_en, 1);
        mem_rd = 1'b0; #0.1;
        chk("R6 no read", rom_read_sel, 0);

        // R7 interrupt-control pulse
        wr(8'h90);
        chk("R7 pulse high", irq_ctl_pulse, 1);
        @(negedge clk);
        chk("R7 pulse one cycle", irq_ctl_pulse, 0);
        wr(8'h80);
        chk("R7 no request", irq_ctl_pulse, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule